// File: doc/BRIEF.md
# PCI Bridge Control and Interrupt Register

This block is a single 32-bit read/write control word that sits in the type 0 configuration window of a host-to-PCI bridge. Address decoding happens upstream. When that decode selects the word, a select strobe reaches this block. Three bits carry meaning:

- The top bit drives the PCI bus reset line directly.
- The next bit lets the PCI interrupt reach the host bus.
- The bit below that reports the raw state of the PCI interrupt and cannot be written.

A host reset is sticky. It puts the PCI bus into reset and masks interrupt routing. Both stay in that state until software writes them back on. Software can also reset the PCI bus by itself, without a host reset, by writing the reset bit high, then low, then high. The PCI interrupt input is active low and asynchronous. It passes through a flip-flop synchronizer before it feeds either the status bit or the routing to the host.

Top module: `pcib_ctl_reg`

## Requirements
- R1: After host reset, `pci_rst_n` is 0 and `host_irq` is 0. A selected read returns 0x2000_0000 when the PCI interrupt is inactive: bit 31 is 0, bit 30 is 0, bit 29 is 1 and all other bits are 0.
- R2: A write occurs on a clock edge where `reg_sel` and `reg_wr` are both 1. That write loads `wr_data[31]` into the reset-release bit, and `pci_rst_n` shows the new value right after that edge.
- R3: Writing bit 31 as 1, then 0, then 1 drives `pci_rst_n` high, then low, then high. This works without any host reset.
- R4: Asserting `host_rst_n` low clears bit 31 and bit 30 at once. Both stay 0 after the host reset is released, until software writes a 1 to them.
- R5: Bit 30 is the interrupt-routing enable and is loaded from `wr_data[30]` on a write. When it is 0, `host_irq` stays 0 whatever the PCI interrupt does.
- R6: Bit 29 reads 0 while the synchronized PCI interrupt is active (`pci_int_n` low) and 1 while it is inactive. Writes to bit 29 have no effect.
- R7: `host_irq` is 1 exactly when bit 30 is 1 and the synchronized PCI interrupt is active.
- R8: Bits 28 down to 0 always read 0, and writing ones to them changes nothing.
- R9: `pci_int_n` passes through two flip-flops. A change on it that is present at clock edge k appears in bit 29 and in `host_irq` right after edge k+1.
- R10: A clock edge where `reg_sel` or `reg_wr` is 0 leaves bits 31 and 30 unchanged.
- R11: `rd_data` is all zeros while `reg_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| host_rst_n | input | 1 | Host reset, active low, asynchronous assert |
| reg_sel | input | 1 | Register selected by the upstream address decode |
| reg_wr | input | 1 | Write enable, taken together with `reg_sel` |
| wr_data | input | 32 | Write data |
| pci_int_n | input | 1 | PCI interrupt, active low, asynchronous |
| pci_rst_n | output | 1 | PCI bus reset, active low |
| host_irq | output | 1 | Interrupt request toward the host, active high |
| rd_data | output | 32 | Read data, zero when not selected |

## Verification
The hardest case to reach is a host reset that arrives while the PCI interrupt is active and both control bits are set. The routing must stay masked after reset release, even though the interrupt line is still low. The stimulus first releases the PCI bus and enables routing. It then holds `pci_int_n` low and pulses `host_rst_n` in the middle of a cycle. For several idle cycles afterwards it checks that `host_irq` and `pci_rst_n` stay 0, and that bit 29 still reports the interrupt as active. Only then does it write the enables back on. A one-cycle glitch on the interrupt input is also driven through, to pin down the two-edge latency.

// File: rtl/pcib_ctl_pkg.sv
package pcib_ctl_pkg;

   // Software-owned control state of the register
   typedef struct packed {
      logic bus_release;   // 1 = PCI bus out of reset
      logic irq_route;     // 1 = PCI interrupt forwarded to the host
   } ctl_bits_t;

   localparam ctl_bits_t CTL_RESET = '{bus_release: 1'b0, irq_route: 1'b0};

   // Interrupt input levels (active low on the PCI side)
   localparam logic INT_IDLE_LVL = 1'b1;

endpackage

// File: rtl/pcib_int_sync.sv
module pcib_int_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_depth
      $error("pcib_int_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_LVL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
      end
   end

   assign dout = chain_q[STAGES-1];

   // R9: the last stage takes the previous value of the stage before it
   p_chain_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (chain_q[STAGES-1] == $past(chain_q[STAGES-2])));

   // R9: the first stage follows the input one edge later
   p_first_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (chain_q[0] == $past(din)));

endmodule

// File: rtl/pcib_ctl_bits.sv
module pcib_ctl_bits
   import pcib_ctl_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int RST_POS = 31,
   parameter int IEN_POS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wdata,
   output ctl_bits_t         bits
);

   if (RST_POS >= DATA_W || IEN_POS >= DATA_W || RST_POS == IEN_POS) begin : g_bad_pos
      $error("pcib_ctl_bits: control bit positions out of range or overlapping");
   end

   ctl_bits_t bits_q;
   ctl_bits_t bits_d;

   always_comb begin
      bits_d = bits_q;
      if (wr_stb) begin
         bits_d.bus_release = wdata[RST_POS];
         bits_d.irq_route   = wdata[IEN_POS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= CTL_RESET;
      end else begin
         bits_q <= bits_d;
      end
   end

   assign bits = bits_q;

   // R4: host reset holds both control bits cleared
   p_reset_clears_r4: assert property (@(posedge clk)
      !rst_n |-> (!bits_q.bus_release && !bits_q.irq_route));

   // R4: a control bit may only rise through an explicit software write
   p_release_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bits_q.bus_release) |-> $past(wr_stb && wdata[RST_POS]));

   p_route_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bits_q.irq_route) |-> $past(wr_stb && wdata[IEN_POS]));

   // R2: a write loads the reset-release bit
   p_write_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (bits_q.bus_release == $past(wdata[RST_POS])));

   // R10: no write strobe, no change
   p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(bits_q));

endmodule

// File: rtl/pcib_rd_mux.sv
module pcib_rd_mux
   import pcib_ctl_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int RST_POS  = 31,
   parameter int IEN_POS  = 30,
   parameter int STAT_POS = 29
) (
   input  logic              sel,
   input  ctl_bits_t         bits,
   input  logic              int_lvl,
   output logic [DATA_W-1:0] rdata
);

   if (STAT_POS >= DATA_W || STAT_POS == RST_POS || STAT_POS == IEN_POS) begin : g_bad_stat
      $error("pcib_rd_mux: status bit position invalid");
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (i == RST_POS) begin : g_rst
         assign rdata[i] = sel & bits.bus_release;
      end else if (i == IEN_POS) begin : g_ien
         assign rdata[i] = sel & bits.irq_route;
      end else if (i == STAT_POS) begin : g_stat
         assign rdata[i] = sel & int_lvl;
      end else begin : g_zero
         assign rdata[i] = 1'b0;
      end
   end

endmodule

// File: rtl/pcib_ctl_reg.sv
module pcib_ctl_reg
   import pcib_ctl_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int RST_POS     = 31,
   parameter int IEN_POS     = 30,
   parameter int STAT_POS    = 29,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              host_rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pci_int_n,
   output logic              pci_rst_n,
   output logic              host_irq,
   output logic [DATA_W-1:0] rd_data
);

   localparam int MIN_W = 3;

   if (DATA_W < MIN_W) begin : g_bad_width
      $error("pcib_ctl_reg: DATA_W too small for the control fields");
   end

   ctl_bits_t bits;
   logic      int_lvl_s;
   logic      int_active;
   logic      wr_stb;

   assign wr_stb = reg_sel & reg_wr;

   pcib_int_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_LVL (INT_IDLE_LVL)
   ) u_sync (
      .clk   (clk),
      .rst_n (host_rst_n),
      .din   (pci_int_n),
      .dout  (int_lvl_s)
   );

   pcib_ctl_bits #(
      .DATA_W  (DATA_W),
      .RST_POS (RST_POS),
      .IEN_POS (IEN_POS)
   ) u_bits (
      .clk    (clk),
      .rst_n  (host_rst_n),
      .wr_stb (wr_stb),
      .wdata  (wr_data),
      .bits   (bits)
   );

   pcib_rd_mux #(
      .DATA_W   (DATA_W),
      .RST_POS  (RST_POS),
      .IEN_POS  (IEN_POS),
      .STAT_POS (STAT_POS)
   ) u_rd (
      .sel     (reg_sel),
      .bits    (bits),
      .int_lvl (int_lvl_s),
      .rdata   (rd_data)
   );

   assign int_active = (int_lvl_s != INT_IDLE_LVL);
   assign pci_rst_n  = bits.bus_release;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge host_rst_n) begin
         if (!host_rst_n) begin
            irq_q <= 1'b0;
         end else begin
            irq_q <= bits.irq_route & int_active;
         end
      end
      assign host_irq = irq_q;
   end else begin : g_irq_comb
      assign host_irq = bits.irq_route & int_active;
   end

   // R1: while host reset is held the PCI bus is in reset and nothing is forwarded
   p_reset_outputs_r1: assert property (@(posedge clk)
      !host_rst_n |-> (!pci_rst_n && !host_irq));

   // R7: an interrupt toward the host needs an active synchronized PCI interrupt
   p_irq_needs_source_r7: assert property (@(posedge clk) disable iff (!host_rst_n)
      host_irq |-> !int_lvl_s);

   // R5: routing disabled keeps the host line quiet
   p_irq_masked_r5: assert property (@(posedge clk) disable iff (!host_rst_n)
      (!bits.irq_route && !IRQ_REG) |-> !host_irq);

endmodule

// File: tb/sim_pcib_ctl_reg.sv
module sim_pcib_ctl_reg;

   logic        clk = 1'b0;
   logic        host_rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] wr_data = '0;
   logic        pci_int_n = 1'b1;
   logic        pci_rst_n;
   logic        host_irq;
   logic [31:0] rd_data;

   int    total = 0;
   int    bad = 0;
   string tag = "R1";
   bit    finished = 1'b0;

   // behavioural reference state
   bit m_rel, m_ien, m_s1, m_s2;

   always #5 clk = ~clk;

   pcib_ctl_reg u0 (
      .clk        (clk),
      .host_rst_n (host_rst_n),
      .reg_sel    (reg_sel),
      .reg_wr     (reg_wr),
      .wr_data    (wr_data),
      .pci_int_n  (pci_int_n),
      .pci_rst_n  (pci_rst_n),
      .host_irq   (host_irq),
      .rd_data    (rd_data)
   );

   always @(posedge clk or negedge host_rst_n) begin
      if (!host_rst_n) begin
         m_rel = 0; m_ien = 0; m_s1 = 1; m_s2 = 1;
      end else begin
         if (reg_sel && reg_wr) begin
            m_rel = wr_data[31];
            m_ien = wr_data[30];
         end
         m_s2 = m_s1;
         m_s1 = pci_int_n;
      end
   end

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic [31:0] exp_rd;
      exp_rd = reg_sel ? {m_rel, m_ien, m_s2, 29'b0} : 32'h0;
      chk("pci_rst_n", {31'b0, pci_rst_n}, {31'b0, m_rel});
      chk("host_irq", {31'b0, host_irq}, {31'b0, (m_ien & ~m_s2)});
      chk("rd_data", rd_data, exp_rd);
   endtask

   // drive after a falling edge, let one rising edge pass, check at the next falling edge
   task automatic cyc(input logic s, input logic w, input logic [31:0] d, input logic irq_n);
      reg_sel = s; reg_wr = w; wr_data = d; pci_int_n = irq_n;
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic idle(input int n, input logic irq_n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 32'h0, irq_n);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, read while held and after release
      tag = "R1";
      @(negedge clk);
      idle(3, 1'b1);
      chk("reset word", rd_data, 32'h2000_0000);
      host_rst_n = 1'b1;
      idle(2, 1'b1);
      chk("pci_rst_n after reset", {31'b0, pci_rst_n}, 32'h0);

      // R2: release the bus
      tag = "R2";
      cyc(1'b1, 1'b1, 32'h8000_0000, 1'b1);
      chk("released", {31'b0, pci_rst_n}, 32'h1);
      idle(1, 1'b1);

      // R3: software pulse 1,0,1
      tag = "R3";
      cyc(1'b1, 1'b1, 32'h0000_0000, 1'b1);
      chk("pulse low", {31'b0, pci_rst_n}, 32'h0);
      cyc(1'b1, 1'b1, 32'h8000_0000, 1'b1);
      chk("pulse high", {31'b0, pci_rst_n}, 32'h1);

      // R8 and R6: ones written to reserved and status bits are dropped
      tag = "R8";
      cyc(1'b1, 1'b1, 32'hBFFF_FFFF, 1'b1);
      chk("reserved ignored", rd_data, 32'hA000_0000);
      tag = "R6";
      cyc(1'b1, 1'b1, 32'hDFFF_FFFF, 1'b1);
      chk("status not writable", rd_data, 32'hE000_0000);

      // R10: writes without select or without enable
      tag = "R10";
      cyc(1'b0, 1'b1, 32'h0000_0000, 1'b1);
      cyc(1'b1, 1'b0, 32'h0000_0000, 1'b1);
      chk("unchanged", rd_data, 32'hE000_0000);

      // R11: unselected read is zero
      tag = "R11";
      cyc(1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);
      chk("unselected read", rd_data, 32'h0);

      // R9 and R7: interrupt becomes active; latency of two edges
      tag = "R9";
      cyc(1'b1, 1'b0, 32'h0, 1'b0);
      chk("not yet seen", {31'b0, host_irq}, 32'h0);
      cyc(1'b1, 1'b0, 32'h0, 1'b0);
      tag = "R7";
      chk("irq raised", {31'b0, host_irq}, 32'h1);
      tag = "R6";
      chk("status active", rd_data, 32'hC000_0000);
      idle(2, 1'b0);

      // R9: one-cycle glitch high passes with the same delay
      tag = "R9";
      cyc(1'b1, 1'b0, 32'h0, 1'b1);
      cyc(1'b1, 1'b0, 32'h0, 1'b0);
      chk("glitch seen", {31'b0, host_irq}, 32'h0);
      cyc(1'b1, 1'b0, 32'h0, 1'b0);
      chk("glitch gone", {31'b0, host_irq}, 32'h1);

      // R5: disable routing while the interrupt is active
      tag = "R5";
      cyc(1'b1, 1'b1, 32'h8000_0000, 1'b0);
      chk("masked", {31'b0, host_irq}, 32'h0);
      idle(2, 1'b0);
      cyc(1'b1, 1'b1, 32'hC000_0000, 1'b0);
      chk("unmasked", {31'b0, host_irq}, 32'h1);

      // R4: host reset mid-cycle with interrupt still active
      tag = "R4";
      #2 host_rst_n = 1'b0;
      #1 chk("async clear", {30'b0, pci_rst_n, host_irq}, 32'h0);
      @(negedge clk);
      idle(2, 1'b0);
      host_rst_n = 1'b1;
      idle(4, 1'b0);
      chk("sticky after release", rd_data, 32'h0000_0000);
      chk("irq stays masked", {31'b0, host_irq}, 32'h0);
      cyc(1'b1, 1'b1, 32'h4000_0000, 1'b0);
      chk("route back on", {30'b0, pci_rst_n, host_irq}, 32'h1);
      cyc(1'b1, 1'b1, 32'hC000_0000, 1'b1);
      chk("bus back", {31'b0, pci_rst_n}, 32'h1);
      idle(3, 1'b1);
      chk("final word", rd_data, 32'hE000_0000);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule